// File: doc/BRIEF.md
# Multiprocessor-Addressed Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with one 8-bit frame format and two 9-bit frame formats. A transmission starts when a byte is loaded. The receiver finds the start edge on an oversampled line and takes one sample from the middle of each bit. A received frame is handed over through a holding register and a receive flag. The transmit and receive flags stay set until software clears them with a one-cycle pulse. A framing-error flag records a bad stop bit.

In the 9-bit formats the receiver can filter frames for a multidrop bus. When multiprocessor filtering is on, frames whose 9th bit is 0 are dropped. A frame whose 9th bit is 1 is an address frame and is accepted only if it matches the local address. The match ignores every bit whose mask bit is 0. A broadcast address is also accepted: its don't-care bits are the positions where both the local address and the mask are 0, and every other bit must be 1.

Bit timing comes from one of two sources. The first is an external tick at 16 times the bit rate. The second is a fixed divide of the system clock, used only in the fixed-rate 9-bit format. In that format a doubling input selects a bit rate of the clock divided by 16 instead of by 32.

Top module: `mpu_uart`

## Requirements
- R1: After reset, txd_o is 1 and ti_o, ri_o and fe_o are 0.
- R2: With mode_i = 2'b01 (8-bit, external tick), a load sends a 0 start bit, then the 8 data bits least significant first, then a 1 stop bit. Each bit lasts 16 ticks of tick16_i.
- R3: With mode_i = 2'b10 or 2'b11 (9-bit), the transmitter sends tx_bit8_i as a 9th bit between the data bits and the stop bit.
- R4: ti_o is set when the stop bit begins on txd_o. It stays set until clr_ti_i is pulsed.
- R5: A load pulse while a frame is being sent is ignored. The frame in progress finishes unchanged.
- R6: When a frame is accepted, ri_o is set and rx_data_o holds the data byte. rx_bit8_o holds the received 9th bit in 9-bit modes, or the stop bit in 8-bit mode.
- R7: A frame whose stop bit is 0 sets fe_o, whether or not the frame is accepted. fe_o stays set until clr_fe_i is pulsed.
- R8: A frame that completes while ri_o is set is discarded, and rx_data_o keeps its value.
- R9: With mp_en_i = 1, a frame whose 9th bit (the stop bit in 8-bit mode) is 0 is discarded.
- R10: With mp_en_i = 1 in a 9-bit mode, an address frame is accepted if it equals slave_addr_i in every position where addr_mask_i is 1.
- R11: With mp_en_i = 1 in a 9-bit mode, an address frame is also accepted if it has a 1 in every position where slave_addr_i | addr_mask_i is 1.
- R12: With mode_i = 2'b10, one bit lasts 32 clock cycles when dbl_i = 0 and 16 clock cycles when dbl_i = 1. tick16_i has no effect in this mode.
- R13: With rx_en_i = 0, frames on rxd_i do not change ri_o, fe_o or rx_data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | External tick at 16x the bit rate (modes 01 and 11) |
| mode_i | input | 2 | Frame format: 00 off, 01 8-bit variable rate, 10 9-bit fixed rate, 11 9-bit variable rate |
| dbl_i | input | 1 | Fixed-rate doubling: 1 selects clk/16, 0 selects clk/32 |
| rx_en_i | input | 1 | Receiver enable |
| mp_en_i | input | 1 | Multiprocessor filtering enable |
| tx_bit8_i | input | 1 | 9th bit to transmit |
| tx_data_i | input | 8 | Byte to transmit |
| tx_load_i | input | 1 | Load pulse that starts a transmission |
| clr_ti_i | input | 1 | Clear pulse for ti_o |
| clr_ri_i | input | 1 | Clear pulse for ri_o |
| clr_fe_i | input | 1 | Clear pulse for fe_o |
| slave_addr_i | input | 8 | Local address |
| addr_mask_i | input | 8 | Address compare mask (0 = don't care) |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| ti_o | output | 1 | Transmit flag |
| ri_o | output | 1 | Receive flag |
| fe_o | output | 1 | Framing-error flag |
| rx_data_o | output | 8 | Received byte |
| rx_bit8_o | output | 1 | Received 9th bit or stop bit |

## Verification
A wrong bit counter or tick counter in the transmitter shows up within one frame. The bit on txd_o at some mid-bit point is wrong, or ti_o rises one bit early or late compared with the start of the stop bit. A receiver that loses its bit alignment puts a shifted byte on rx_data_o, or sets fe_o, as soon as the frame completes. A bad address or broadcast compare shows as a change on ri_o that should not happen, or a missing one, by the end of the stop bit of the address frame.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_8V  = 2'b01,
    MODE_9F  = 2'b10,
    MODE_9V  = 2'b11
  } mode_e;

  function automatic logic is_nine(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/mpu_baud.sv
module mpu_baud
  import mpu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       dbl_i,
  input  logic       tick_ext_i,
  output logic       tick_o
);
  logic div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= ~div_q;
  end

  always_comb begin
    unique case (mode_e'(mode_i))
      MODE_9F:  tick_o = dbl_i ? 1'b1 : div_q;
      MODE_OFF: tick_o = 1'b0;
      default:  tick_o = tick_ext_i;
    endcase
  end

  // R12: fixed divide without doubling never ticks on two cycles in a row
  p_fixed_div_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && !dbl_i && tick_o && $stable(mode_i) && $stable(dbl_i))
      |=> (!tick_o || mode_i != 2'b10 || dbl_i));
endmodule

// File: rtl/mpu_tx.sv
module mpu_tx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          nine_i,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          bit8_i,
  output logic          txd_o,
  output logic          ti_set_o
);
  localparam int FW = DW + 3;
  localparam int BW = $clog2(FW + 1);
  localparam int CW = $clog2(OSR);

  logic [FW-1:0] sh_q;
  logic [BW-1:0] left_q;
  logic [CW-1:0] tcnt_q;
  logic          busy_q;
  logic          bit_end;

  assign bit_end  = busy_q && tick_i && (tcnt_q == CW'(OSR - 1));
  assign ti_set_o = bit_end && (left_q == BW'(2));
  assign txd_o    = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      tcnt_q <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (load_i && en_i) begin
        sh_q   <= {1'b1, (nine_i ? bit8_i : 1'b1), data_i, 1'b0};
        left_q <= nine_i ? BW'(FW) : BW'(FW - 1);
        tcnt_q <= '0;
        busy_q <= 1'b1;
      end
    end else if (tick_i) begin
      if (bit_end) begin
        tcnt_q <= '0;
        sh_q   <= {1'b1, sh_q[FW-1:1]};
        left_q <= left_q - BW'(1);
        if (left_q == BW'(1)) busy_q <= 1'b0;
      end else begin
        tcnt_q <= tcnt_q + CW'(1);
      end
    end
  end

  // R2: an accepted load drives the start bit on the next cycle
  p_start_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && en_i && !busy_q) |=> (busy_q && !txd_o));
  // R5: a load during a frame leaves the remaining bit count alone
  p_load_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && load_i && !tick_i) |=> $stable(left_q));
endmodule

// File: rtl/mpu_rx.sv
module mpu_rx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          nine_i,
  input  logic          tick_i,
  input  logic          rxd_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          bit8_o,
  output logic          stop_o
);
  localparam int CW  = $clog2(OSR);
  localparam int IW  = $clog2(DW + 3);
  localparam int MID = OSR / 2 - 1;

  logic          s1_q, s2_q, prev_q, busy_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_idx;

  assign last_idx = nine_i ? IW'(DW + 2) : IW'(DW + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1; s2_q <= 1'b1;
    end else begin
      s1_q <= rxd_i; s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      done_o <= 1'b0;
      data_o <= '0;
      bit8_o <= 1'b0;
      stop_o <= 1'b1;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        busy_q <= 1'b0;
        prev_q <= 1'b1;
      end else if (tick_i) begin
        if (!busy_q) begin
          prev_q <= s2_q;
          if (prev_q && !s2_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            idx_q  <= '0;
          end
        end else begin
          cnt_q <= (cnt_q == CW'(OSR - 1)) ? '0 : cnt_q + CW'(1);
          if (cnt_q == CW'(MID)) begin
            if (idx_q == last_idx) begin
              stop_o <= s2_q;
              if (!nine_i) bit8_o <= s2_q;
              done_o <= 1'b1;
              busy_q <= 1'b0;
              prev_q <= s2_q;
            end else if (idx_q == '0) begin
              if (s2_q) begin  // glitch, not a start bit
                busy_q <= 1'b0;
                prev_q <= 1'b1;
              end else idx_q <= idx_q + IW'(1);
            end else if (idx_q == IW'(DW + 1)) begin
              bit8_o <= s2_q;
              idx_q  <= idx_q + IW'(1);
            end else begin
              data_o <= {s2_q, data_o[DW-1:1]};
              idx_q  <= idx_q + IW'(1);
            end
          end
        end
      end
    end
  end

  // R13: a disabled receiver reports no frame
  p_no_done_disabled_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> !done_o);
endmodule

// File: rtl/mpu_addr.sv
module mpu_addr #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rx_i,
  input  logic [DW-1:0] saddr_i,
  input  logic [DW-1:0] mask_i,
  output logic          hit_o
);
  logic [DW-1:0] bcast;
  logic          own_hit, bc_hit;

  assign bcast   = saddr_i | mask_i;
  assign own_hit = ((rx_i ^ saddr_i) & mask_i) == '0;
  assign bc_hit  = (rx_i & bcast) == bcast;
  assign hit_o   = own_hit | bc_hit;
endmodule

// File: rtl/mpu_uart.sv
module mpu_uart
  import mpu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic [1:0]    mode_i,
  input  logic          dbl_i,
  input  logic          rx_en_i,
  input  logic          mp_en_i,
  input  logic          tx_bit8_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_load_i,
  input  logic          clr_ti_i,
  input  logic          clr_ri_i,
  input  logic          clr_fe_i,
  input  logic [DW-1:0] slave_addr_i,
  input  logic [DW-1:0] addr_mask_i,
  input  logic          rxd_i,
  output logic          txd_o,
  output logic          ti_o,
  output logic          ri_o,
  output logic          fe_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_bit8_o
);
  logic          tick, nine, ti_set;
  logic          rx_done, rx_b8, rx_stop, hit, accept;
  logic [DW-1:0] rx_byte;

  assign nine = is_nine(mode_i);

  mpu_baud u_baud (
    .clk_i, .rst_ni, .mode_i, .dbl_i,
    .tick_ext_i(tick16_i), .tick_o(tick)
  );

  mpu_tx #(.DW(DW), .OSR(OSR)) u_tx (
    .clk_i, .rst_ni, .en_i(mode_i != 2'b00), .nine_i(nine), .tick_i(tick),
    .load_i(tx_load_i), .data_i(tx_data_i), .bit8_i(tx_bit8_i),
    .txd_o, .ti_set_o(ti_set)
  );

  mpu_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk_i, .rst_ni, .en_i(rx_en_i && mode_i != 2'b00), .nine_i(nine),
    .tick_i(tick), .rxd_i, .done_o(rx_done), .data_o(rx_byte),
    .bit8_o(rx_b8), .stop_o(rx_stop)
  );

  mpu_addr #(.DW(DW)) u_addr (
    .rx_i(rx_byte), .saddr_i(slave_addr_i), .mask_i(addr_mask_i), .hit_o(hit)
  );

  assign accept = rx_done && !ri_o && (!mp_en_i || (rx_b8 && (!nine || hit)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ti_o      <= 1'b0;
      ri_o      <= 1'b0;
      fe_o      <= 1'b0;
      rx_data_o <= '0;
      rx_bit8_o <= 1'b0;
    end else begin
      if (ti_set)        ti_o <= 1'b1;
      else if (clr_ti_i) ti_o <= 1'b0;
      if (accept) begin
        ri_o      <= 1'b1;
        rx_data_o <= rx_byte;
        rx_bit8_o <= rx_b8;
      end else if (clr_ri_i) ri_o <= 1'b0;
      if (rx_done && !rx_stop) fe_o <= 1'b1;
      else if (clr_fe_i)       fe_o <= 1'b0;
    end
  end

  // R4: TI holds until cleared
  p_ti_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ti_o && !clr_ti_i) |=> ti_o);
  // R8: while RI is held the received data does not move
  p_ri_holds_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_o && !clr_ri_i) |=> (ri_o && $stable(rx_data_o)));
  // R7: framing flag holds until cleared
  p_fe_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_o && !clr_fe_i) |=> fe_o);
  // R9: a data frame under filtering never raises RI
  p_mp_reject_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && mp_en_i && !rx_b8 && !ri_o) |=> !ri_o);
endmodule

// File: tb/mpu_uart_test.sv
module mpu_uart_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       dbl = 1'b0, rx_en = 1'b1, mp_en = 1'b0, tx_b8 = 1'b0;
  logic [7:0] tx_data = 8'h00, saddr = 8'h00, amask = 8'h00;
  logic       tx_load = 1'b0, clr_ti = 1'b0, clr_ri = 1'b0, clr_fe = 1'b0;
  logic       rxd = 1'b1;
  logic       txd, ti, ri, fe, rx_b8;
  logic [7:0] rx_data;
  int         n_tests = 0, n_fail = 0;
  logic [1:0] tdiv = 2'd0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  mpu_uart uut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick16), .mode_i(mode), .dbl_i(dbl),
    .rx_en_i(rx_en), .mp_en_i(mp_en), .tx_bit8_i(tx_b8), .tx_data_i(tx_data),
    .tx_load_i(tx_load), .clr_ti_i(clr_ti), .clr_ri_i(clr_ri), .clr_fe_i(clr_fe),
    .slave_addr_i(saddr), .addr_mask_i(amask), .rxd_i(rxd), .txd_o(txd),
    .ti_o(ti), .ri_o(ri), .fe_o(fe), .rx_data_o(rx_data), .rx_bit8_o(rx_b8)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  // sends a frame on txd and checks each bit at mid-bit
  task automatic tx_frame(input string tag, input logic [7:0] d, input logic b8,
                          input logic nine, input int p, input logic inject);
    logic [10:0] exp;
    int nb;
    exp = nine ? {1'b1, b8, d, 1'b0} : {2'b11, d, 1'b0};
    nb  = nine ? 11 : 10;
    @(negedge clk) begin tx_data = d; tx_b8 = b8; tx_load = 1'b1; end
    @(negedge clk) tx_load = 1'b0;
    if (inject) begin
      @(negedge clk) begin tx_data = ~d; tx_load = 1'b1; end
      @(negedge clk) tx_load = 1'b0;
      repeat (p / 2 - 3) @(negedge clk);
    end else repeat (p / 2 - 1) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      check($sformatf("%s bit%0d", tag, i), {15'd0, txd}, {15'd0, exp[i]});
      if (i == nb - 2) check({tag, " R4 ti low before stop"}, {15'd0, ti}, 16'd0);
      if (i == nb - 1) check({tag, " R4 ti at stop"}, {15'd0, ti}, 16'd1);
      repeat (p) @(negedge clk);
    end
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic b8, input logic nine,
                          input logic stopv, input int p);
    @(negedge clk) rxd = 1'b0;
    repeat (p - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (p) @(negedge clk);
    end
    if (nine) begin
      rxd = b8;
      repeat (p) @(negedge clk);
    end
    rxd = stopv;
    repeat (p) @(negedge clk);
    rxd = 1'b1;
    repeat (p) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 txd idle", {15'd0, txd}, 16'd1);
    check("R1 flags", {13'd0, ti, ri, fe}, 16'd0);
  endtask

  task automatic t_tx;
    mode = 2'b01;
    tx_frame("R2 8bit 96", 8'h96, 1'b0, 1'b0, 64, 1'b0);
    pulse(clr_ti);
    check("R4 ti cleared", {15'd0, ti}, 16'd0);
    mode = 2'b11;
    tx_frame("R3 9bit b8=1", 8'h3C, 1'b1, 1'b1, 64, 1'b0);
    pulse(clr_ti);
    tx_frame("R3 9bit b8=0", 8'hC3, 1'b0, 1'b1, 64, 1'b0);
    pulse(clr_ti);
    mode = 2'b01;
    tx_frame("R5 busy load", 8'h5A, 1'b0, 1'b0, 64, 1'b1);
    pulse(clr_ti);
  endtask

  task automatic t_rx8;
    mode = 2'b01; mp_en = 1'b0;
    rx_frame(8'hA5, 1'b0, 1'b0, 1'b1, 64);
    check("R6 ri set", {15'd0, ri}, 16'd1);
    check("R6 data", {8'd0, rx_data}, 16'h00A5);
    check("R6 stop in bit8", {15'd0, rx_b8}, 16'd1);
    rx_frame(8'h11, 1'b0, 1'b0, 1'b1, 64);
    check("R8 data kept", {8'd0, rx_data}, 16'h00A5);
    pulse(clr_ri);
    check("R6 ri cleared", {15'd0, ri}, 16'd0);
    rx_frame(8'h3E, 1'b0, 1'b0, 1'b0, 64);
    check("R7 fe set", {15'd0, fe}, 16'd1);
    check("R7 bad stop bit8", {15'd0, rx_b8}, 16'd0);
    pulse(clr_fe); pulse(clr_ri);
    check("R7 fe cleared", {15'd0, fe}, 16'd0);
    mode = 2'b11;
    rx_frame(8'h77, 1'b0, 1'b1, 1'b1, 64);
    check("R6 9bit data", {7'd0, rx_b8, rx_data}, 16'h0077);
    pulse(clr_ri);
  endtask

  task automatic t_mp;
    mode = 2'b11; mp_en = 1'b1; saddr = 8'h35; amask = 8'hF0;
    rx_frame(8'h3A, 1'b0, 1'b1, 1'b1, 64);
    check("R9 data frame dropped", {15'd0, ri}, 16'd0);
    rx_frame(8'h3A, 1'b1, 1'b1, 1'b1, 64);
    check("R10 masked match", {7'd0, ri, rx_data}, 16'h013A);
    pulse(clr_ri);
    rx_frame(8'h45, 1'b1, 1'b1, 1'b1, 64);
    check("R10 mismatch", {15'd0, ri}, 16'd0);
    rx_frame(8'hFF, 1'b1, 1'b1, 1'b1, 64);
    check("R11 broadcast", {7'd0, ri, rx_data}, 16'h01FF);
    pulse(clr_ri);
    rx_frame(8'hF4, 1'b1, 1'b1, 1'b1, 64);
    check("R11 not broadcast", {15'd0, ri}, 16'd0);
    mp_en = 1'b0;
  endtask

  task automatic t_fixed;
    mode = 2'b10; dbl = 1'b0;
    tx_frame("R12 clk/32", 8'hB1, 1'b1, 1'b1, 32, 1'b0);
    pulse(clr_ti);
    dbl = 1'b1;
    tx_frame("R12 clk/16", 8'h4E, 1'b0, 1'b1, 16, 1'b0);
    pulse(clr_ti);
    rx_frame(8'hC9, 1'b1, 1'b1, 1'b1, 16);
    check("R12 rx clk/16", {7'd0, rx_b8, rx_data}, 16'h01C9);
    pulse(clr_ri);
    dbl = 1'b0;
  endtask

  task automatic t_rxen;
    mode = 2'b01; rx_en = 1'b0;
    rx_frame(8'h5C, 1'b0, 1'b0, 1'b0, 64);
    check("R13 disabled", {6'd0, ri, fe, rx_data}, 16'h00C9);
    rx_en = 1'b1;
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx();
    t_rx8();
    t_mp();
    t_fixed();
    t_rxen();
    finish_up();
  end
endmodule